// File: doc/BRIEF.md
# Remote Interrupt Router

This block takes the interrupt requests of two remote link receivers and steers them onto two active-low local pins: a remote-interrupt pin and a general interrupt pin. A remote request is honoured only while its port reports a valid link. Local protected-content interrupt sources also feed the general pin, and each one counts only when its enable bit is set.

Software picks a routing mode through a small register interface. In combined mode, either port pulls the remote-interrupt pin low. In split mode, port 0 drives the remote-interrupt pin as a live level. Port 1 sets a sticky status bit that holds the general pin low until software reads the status register. A fallback bit turns both pins into plain level copies of the two port inputs, with no latching and no inversion.

Top module: `rem_irq_router`

## Requirements
- R1: After reset both pins read 1, the control register (0x30) reads 0, the enable register (0x31) reads 0 and the status register (0x32) reads 0.
- R2: A remote request from a port whose link-valid input is low counts as inactive in combined and split modes.
- R3: In combined mode (control bits [3:0] = 0), the remote pin is low one cycle after either qualified remote request is high. Otherwise it is 1.
- R4: Mode values other than 0 and 1 behave exactly like combined mode.
- R5: In split mode (control bits [3:0] = 1), the remote pin follows only the qualified port 0 request, one cycle late, with no latching.
- R6: In split mode, a qualified port 1 request sets status bit 0. The general pin is low while that bit is set or any enabled local source is high.
- R7: A read of 0x32 returns the latched port 1 bit in bit 0 and clears it, unless port 1 is requesting in the same cycle. The general pin deasserts on the cycle after the clear.
- R8: In combined and split modes, local source i reaches the general pin only when bit i of the enable register (0x31) is set.
- R9: With control bit 4 set (fallback), each pin copies its port's request level one cycle late, with no inversion and no latching. Local sources are ignored, and a pin whose link is invalid reads 1.
- R10: Register reads return data on the cycle after the read strobe. The control register returns {3'b0, fallback, mode} and the enable register returns the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rem_irq_i | input | 2 | Remote interrupt request per port, active high |
| link_ok_i | input | 2 | Link-valid qualifier per port |
| loc_irq_i | input | N_LOC | Local protected-content interrupt sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid one cycle after the read |
| rem_irq_n_o | output | 1 | Remote-interrupt pin, active low |
| gen_irq_n_o | output | 1 | General interrupt pin, active low |

## Verification
The bench builds the block with the default of eight local sources, so each enable bit can be exercised on its own and the enable register is read back at full width. Random traffic sweeps the mode field over the combined, split, reserved and fallback settings, mixing link drops with status reads. This brings within reach the cases where a status read meets a new port 1 request in the same cycle, and mode changes while a status bit is latched.

// File: rtl/rir_pkg.sv
package rir_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h30;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 8'h31;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h32;
    localparam logic [3:0] MODE_COMB  = 4'h0;
    localparam logic [3:0] MODE_SPLIT = 4'h1;
    localparam int FB_BIT = 4;
endpackage

// File: rtl/rir_regs.sv
module rir_regs
    import rir_pkg::*;
#(
    parameter int N_LOC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              lat_i,
    output logic [3:0]        mode_o,
    output logic              fb_o,
    output logic [N_LOC-1:0]  ien_o,
    output logic              stat_rd_o,
    output logic [REG_W-1:0]  rdata_o
);
    typedef struct packed {
        logic [3:0]       mode;
        logic             fb;
        logic [N_LOC-1:0] ien;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        stat_rd_o = rd_i && (addr_i == ADDR_STAT);
        if (rd_i) begin
            case (addr_i)
                ADDR_CTRL: s_d.rdata = REG_W'({s_q.fb, s_q.mode});
                ADDR_IEN:  s_d.rdata = REG_W'(s_q.ien);
                ADDR_STAT: s_d.rdata = REG_W'(lat_i);
                default:   s_d.rdata = '0;
            endcase
        end
        if (wr_i) begin
            case (addr_i)
                ADDR_CTRL: begin
                    s_d.mode = wdata_i[3:0];
                    s_d.fb   = wdata_i[FB_BIT];
                end
                ADDR_IEN:  s_d.ien = wdata_i[N_LOC-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_o  = s_q.mode;
    assign fb_o    = s_q.fb;
    assign ien_o   = s_q.ien;
    assign rdata_o = s_q.rdata;
endmodule

// File: rtl/rir_route.sv
module rir_route
    import rir_pkg::*;
#(
    parameter int N_LOC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             fb_i,
    input  logic [N_LOC-1:0] ien_i,
    input  logic             stat_rd_i,
    input  logic [1:0]       req_i,
    input  logic [1:0]       link_i,
    input  logic [N_LOC-1:0] loc_i,
    output logic             lat_o,
    output logic             rem_n_o,
    output logic             int_n_o
);
    typedef struct packed {
        logic rem_n;
        logic int_n;
        logic lat;
    } route_t;

    route_t s_d, s_q;
    logic [1:0] qual;
    logic       split;
    logic       loc_any;

    always_comb begin
        qual    = req_i & link_i;
        split   = (mode_i == MODE_SPLIT) && !fb_i;
        loc_any = |(loc_i & ien_i);
        s_d     = s_q;
        if (fb_i) begin
            s_d.rem_n = link_i[0] ? req_i[0] : 1'b1;
            s_d.int_n = link_i[1] ? req_i[1] : 1'b1;
            s_d.lat   = 1'b0;
        end else if (split) begin
            s_d.rem_n = !qual[0];
            s_d.int_n = !(s_q.lat || loc_any);
            s_d.lat   = (s_q.lat && !stat_rd_i) || qual[1];
        end else begin
            s_d.rem_n = !(|qual);
            s_d.int_n = !loc_any;
            s_d.lat   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{rem_n: 1'b1, int_n: 1'b1, lat: 1'b0};
        else        s_q <= s_d;
    end

    assign lat_o   = s_q.lat;
    assign rem_n_o = s_q.rem_n;
    assign int_n_o = s_q.int_n;
endmodule

// File: rtl/rem_irq_router.sv
module rem_irq_router
    import rir_pkg::*;
#(
    parameter int N_LOC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rem_irq_i,
    input  logic [1:0]        link_ok_i,
    input  logic [N_LOC-1:0]  loc_irq_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              rem_irq_n_o,
    output logic              gen_irq_n_o
);
    logic [3:0]       mode_w;
    logic             fb_w;
    logic [N_LOC-1:0] ien_w;
    logic             stat_rd_w;
    logic             lat_w;

    rir_regs #(.N_LOC(N_LOC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .lat_i(lat_w),
        .mode_o(mode_w), .fb_o(fb_w), .ien_o(ien_w),
        .stat_rd_o(stat_rd_w), .rdata_o(reg_rdata_o)
    );

    rir_route #(.N_LOC(N_LOC)) u_route (
        .clk(clk), .rst_n(rst_n),
        .mode_i(mode_w), .fb_i(fb_w), .ien_i(ien_w), .stat_rd_i(stat_rd_w),
        .req_i(rem_irq_i), .link_i(link_ok_i), .loc_i(loc_irq_i),
        .lat_o(lat_w), .rem_n_o(rem_irq_n_o), .int_n_o(gen_irq_n_o)
    );
endmodule

// File: rtl/rir_checker.sv
module rir_checker
    import rir_pkg::*;
#(
    parameter int N_LOC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rem_irq_i,
    input logic [1:0]        link_ok_i,
    input logic [N_LOC-1:0]  loc_irq_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [3:0]        mode,
    input logic              fb,
    input logic [N_LOC-1:0]  ien,
    input logic              lat,
    input logic              rem_n,
    input logic              int_n
);
    logic split;
    assign split = (mode == MODE_SPLIT) && !fb;

    p_link_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb && link_ok_i == 2'b00) |=> rem_n);

    p_comb_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb && mode != MODE_SPLIT && |(rem_irq_i & link_ok_i)) |=> !rem_n);

    p_split_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !(rem_irq_i[0] && link_ok_i[0])) |=> rem_n);

    p_split_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (split && lat) |=> !int_n);

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (split && reg_rd_i && reg_addr_i == ADDR_STAT && !(rem_irq_i[1] && link_ok_i[1])) |=> !lat);

    p_en_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb && mode != MODE_SPLIT && (loc_irq_i & ien) == '0) |=> int_n);

    p_fb_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fb && link_ok_i[0]) |=> (rem_n == $past(rem_irq_i[0])));
endmodule

bind rem_irq_router rir_checker #(.N_LOC(N_LOC)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rem_irq_i(rem_irq_i), .link_ok_i(link_ok_i), .loc_irq_i(loc_irq_i),
    .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .mode(mode_w), .fb(fb_w), .ien(ien_w), .lat(lat_w),
    .rem_n(rem_irq_n_o), .int_n(gen_irq_n_o)
);

// File: tb/tb_rem_irq_router.sv
`timescale 1ns/1ps
module tb_rem_irq_router;
    localparam int N = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] ri = '0, lk = '0;
    logic [N-1:0] loc = '0;
    logic wr = 0, rd = 0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic rem_n, int_n;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench-side expected state
    logic [3:0] m_mode = '0;
    logic m_fb = 0, m_lat = 0, m_rem = 1, m_int = 1, m_rdv = 0;
    logic [N-1:0] m_ien = '0;
    logic [7:0] m_rdata = '0;

    always #2 clk = ~clk;

    rem_irq_router #(.N_LOC(N)) dut (
        .clk(clk), .rst_n(rst_n), .rem_irq_i(ri), .link_ok_i(lk), .loc_irq_i(loc),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .rem_irq_n_o(rem_n), .gen_irq_n_o(int_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rem_tag();
        if (m_fb) return "R9";
        if (m_mode == 4'h1) return "R5";
        if (m_mode == 4'h0) return "R3";
        return "R4";
    endfunction

    function automatic string int_tag();
        if (m_fb) return "R9";
        if (m_mode == 4'h1) return "R6";
        return "R8";
    endfunction

    task automatic model_step();
        logic [1:0] q;
        logic split, la, srd, n_rem, n_int, n_lat;
        q     = ri & lk;
        split = (m_mode == 4'h1) && !m_fb;
        la    = |(loc & m_ien);
        srd   = rd && (addr == 8'h32);
        n_rem = m_fb ? (lk[0] ? ri[0] : 1'b1) : split ? !q[0] : !(|q);
        n_int = m_fb ? (lk[1] ? ri[1] : 1'b1) : split ? !(m_lat || la) : !la;
        n_lat = split ? ((m_lat && !srd) || q[1]) : 1'b0;
        m_rdv = rd;
        if (rd) begin
            case (addr)
                8'h30:   m_rdata = {3'b0, m_fb, m_mode};
                8'h31:   m_rdata = 8'(m_ien);
                8'h32:   m_rdata = {7'b0, m_lat};
                default: m_rdata = 8'h00;
            endcase
        end
        if (wr && addr == 8'h30) begin m_mode = wdata[3:0]; m_fb = wdata[4]; end
        if (wr && addr == 8'h31) m_ien = wdata[N-1:0];
        m_rem = n_rem; m_int = n_int; m_lat = n_lat;
    endtask

    // one clock: model update at the edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        #0.5 model_step();
        @(negedge clk);
        chk(rem_tag(), {7'b0, rem_n}, {7'b0, m_rem});
        chk(int_tag(), {7'b0, int_n}, {7'b0, m_int});
        if (m_rdv) chk("R10", rdata, m_rdata);
        wr = 0; rd = 0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        wr = 1; addr = a; wdata = d; cyc();
    endtask

    task automatic rreg(input logic [7:0] a);
        rd = 1; addr = a; cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rem pin in reset", {7'b0, rem_n}, 8'h01);
        chk("R1 gen pin in reset", {7'b0, int_n}, 8'h01);
        rst_n = 1;
        rreg(8'h30); chk("R1 ctrl", rdata, 8'h00);
        rreg(8'h31); chk("R1 ien", rdata, 8'h00);
        rreg(8'h32); chk("R1 stat", rdata, 8'h00);

        // R2: requests with links down
        ri = 2'b11; lk = 2'b00; cyc(); cyc();
        chk("R2 masked", {7'b0, rem_n}, 8'h01);
        // R3: one port in combined mode
        lk = 2'b11; ri = 2'b01; cyc(); cyc();
        chk("R3 port0", {7'b0, rem_n}, 8'h00);
        ri = 2'b10; cyc(); chk("R3 port1", {7'b0, rem_n}, 8'h00);
        ri = 2'b00; cyc(); chk("R3 idle", {7'b0, rem_n}, 8'h01);
        // R8: enable gating
        loc = 8'hFB; cyc(); chk("R8 disabled", {7'b0, int_n}, 8'h01);
        wreg(8'h31, 8'h04); loc = 8'h04; cyc();
        chk("R8 enabled", {7'b0, int_n}, 8'h00);
        loc = 8'h00; wreg(8'h31, 8'h00);
        // R4: reserved mode
        wreg(8'h30, 8'h05); ri = 2'b10; cyc(); cyc();
        chk("R4 reserved=combined", {7'b0, rem_n}, 8'h00);
        ri = 2'b00;
        // R6/R7: split latch and clear
        wreg(8'h30, 8'h01); ri = 2'b10; cyc(); ri = 2'b00; cyc();
        chk("R5 port1 not on rem", {7'b0, rem_n}, 8'h01);
        repeat (3) cyc();
        chk("R6 latched", {7'b0, int_n}, 8'h00);
        rreg(8'h32); chk("R7 stat bit", rdata, 8'h01);
        chk("R7 still low at clear", {7'b0, int_n}, 8'h00);
        cyc(); chk("R7 deassert", {7'b0, int_n}, 8'h01);
        // R9: fallback copies levels
        wreg(8'h30, 8'h10); ri = 2'b00; cyc(); cyc();
        chk("R9 rem copy", {7'b0, rem_n}, 8'h00);
        chk("R9 gen copy", {7'b0, int_n}, 8'h00);
        lk = 2'b00; cyc(); cyc();
        chk("R9 link down", {7'b0, int_n}, 8'h01);

        // random traffic
        void'($urandom(32'h5EED_0941));
        for (int i = 0; i < 3000; i++) begin
            int sel;
            ri  = 2'($urandom);
            lk  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
            loc = ($urandom_range(0, 2) == 0) ? N'($urandom) : '0;
            sel = $urandom_range(0, 19);
            if (sel == 0) begin
                logic [7:0] mv;
                case ($urandom_range(0, 3))
                    0: mv = 8'h00; 1: mv = 8'h01; 2: mv = 8'h10; default: mv = 8'h07;
                endcase
                wr = 1; addr = 8'h30; wdata = mv;
            end else if (sel == 1) begin
                wr = 1; addr = 8'h31; wdata = 8'($urandom);
            end else if (sel < 6) begin
                rd = 1; addr = 8'h30 + 8'($urandom_range(0, 3));
            end
            cyc();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule